// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a virtual address into a physical address by walking a two-level page table held in memory. Each request's virtual address is split into three fields. The top field selects an entry in a root directory. That directory entry gives the base of a second-level table, which is exactly one page long. The middle field selects an entry in that table, and the entry gives the page frame. The low field is the byte offset and is carried through unchanged.

Tables are read through a synchronous read port with a fixed latency of one cycle. Only one walk is in flight at a time. A walk can end in one of three ways: a successful translation, a fault because the second-level table is missing, or a fault because the page is missing. Every response also returns the virtual address that was translated.

The controller has five states: WALK_IDLE, WALK_READ_DIR, WALK_READ_PTE, WALK_DONE and WALK_FAULT. The transitions are:
- WALK_IDLE goes to WALK_READ_DIR when a request arrives. The directory read is issued in that same cycle.
- WALK_READ_DIR goes to WALK_READ_PTE and issues the second read when the returned directory entry is present. Otherwise it goes to WALK_FAULT.
- WALK_READ_PTE goes to WALK_DONE when the returned page entry is present. Otherwise it goes to WALK_FAULT.
- WALK_DONE and WALK_FAULT each present the response for one cycle and then return to WALK_IDLE.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address is {dir index (DIR_BITS), table index (IDX_BITS), offset (OFF_BITS)}, most significant field first. OFF_BITS equals IDX_BITS + log2(ENTRY_BYTES), so that one second-level table fills one page. The defaults are 3, 4 and 6 bits.
- R2: In the cycle a request is accepted, mem_req is high and mem_addr equals root_base + dir_index × ENTRY_BYTES.
- R3: In both levels, bit 0 of an entry is the present flag and bits [PA_BITS-1:OFF_BITS] are a page number. All other entry bits are ignored.
- R4: If the directory entry is present, a read of table_base + table_index × ENTRY_BYTES is issued in the cycle after acceptance. table_base is the directory entry's page number followed by OFF_BITS zeros.
- R5: On success, rsp_valid is high in the third cycle after acceptance, with rsp_fault = 00 and rsp_paddr = {frame page number, offset}.
- R6: If the directory entry is absent, no second read is made. rsp_valid is high in the second cycle after acceptance, with rsp_fault = 01 and rsp_paddr = 0.
- R7: If the second-level entry is absent, rsp_valid is high in the third cycle after acceptance, with rsp_fault = 10 and rsp_paddr = 0.
- R8: Every response carries rsp_vaddr equal to the accepted virtual address.
- R9: req_ready is high only while idle. Requests presented while a walk is in progress are ignored.
- R10: After reset the walker is idle: req_ready is 1, rsp_valid is 0, and mem_req is 0 while req_valid is 0.
- R11: rsp_valid lasts exactly one cycle, and the walker is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | PA_BITS | Byte address of the root directory |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | VA_BITS | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| mem_req | output | 1 | Table read strobe |
| mem_addr | output | PA_BITS | Table read byte address |
| mem_rdata | input | 8×ENTRY_BYTES | Entry returned one cycle after mem_req |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 2 | 00 ok, 01 no second-level table, 10 no page |
| rsp_paddr | output | PA_BITS | Physical address, zero on fault |
| rsp_vaddr | output | VA_BITS | Virtual address of this response |

## Verification
Every directory index, every table index, and three offsets (zero, all ones, and a mixed value) are swept under four presence patterns:
- All entries present. This checks that the frame and offset are joined correctly and that both read addresses are right.
- Odd directory entries absent. This separates the directory-level fault, and its shorter latency, from success.
- One absent page per table. This isolates the page-level fault.
- A mixed pattern.

The root base alternates between rounds, which shows that the directory address follows root_base rather than a fixed value. Entries carry junk in their unused bits, which shows that those bits are ignored. A different request is held on the inputs for the whole of each walk, which shows that it is not taken.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        WALK_IDLE,
        WALK_READ_DIR,
        WALK_READ_PTE,
        WALK_DONE,
        WALK_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_DIR  = 2'b01,
        FLT_PAGE = 2'b10
    } walk_fault_e;

endpackage

// File: rtl/ptw_entry_addr.sv
// Byte address of a table entry: base + index scaled by the entry size.
module ptw_entry_addr #(
    parameter int PA_BITS     = 16,
    parameter int IDX_W       = 4,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [PA_BITS-1:0] base,
    input  logic [IDX_W-1:0]   index,
    output logic [PA_BITS-1:0] addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);

    logic [PA_BITS-1:0] index_ext;

    always_comb begin
        index_ext = {{(PA_BITS-IDX_W){1'b0}}, index};
        addr      = base + (index_ext << SHIFT);
    end
endmodule

// File: rtl/ptw_entry_decode.sv
// Splits a table entry into its present flag and its page number.
module ptw_entry_decode #(
    parameter int ENTRY_W  = 32,
    parameter int PA_BITS  = 16,
    parameter int OFF_BITS = 6
) (
    input  logic [ENTRY_W-1:0]          entry,
    output logic                        present,
    output logic [PA_BITS-OFF_BITS-1:0] page_num
);
    always_comb begin
        present  = entry[0];
        page_num = entry[PA_BITS-1:OFF_BITS];
    end
endmodule

// File: rtl/ptw_resp_reg.sv
// Holds the result of the last walk until the next one completes.
module ptw_resp_reg #(
    parameter int PA_BITS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [1:0]         fault_in,
    input  logic [PA_BITS-1:0] paddr_in,
    output logic [1:0]         fault_q,
    output logic [PA_BITS-1:0] paddr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= '0;
            paddr_q <= '0;
        end else if (load) begin
            fault_q <= fault_in;
            paddr_q <= paddr_in;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int DIR_BITS    = 3,
    parameter int IDX_BITS    = 4,
    parameter int ENTRY_BYTES = 4,
    parameter int PA_BITS     = 16,
    localparam int OFF_BITS   = IDX_BITS + $clog2(ENTRY_BYTES),
    localparam int VA_BITS    = DIR_BITS + IDX_BITS + OFF_BITS,
    localparam int ENTRY_W    = 8 * ENTRY_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PA_BITS-1:0] root_base,
    input  logic               req_valid,
    input  logic [VA_BITS-1:0] req_vaddr,
    output logic               req_ready,
    output logic               mem_req,
    output logic [PA_BITS-1:0] mem_addr,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic               rsp_valid,
    output logic [1:0]         rsp_fault,
    output logic [PA_BITS-1:0] rsp_paddr,
    output logic [VA_BITS-1:0] rsp_vaddr
);
    localparam int PN_BITS = PA_BITS - OFF_BITS;

    walk_state_e          state_q, state_d;
    logic [VA_BITS-1:0]   va_q;
    logic                 accept;

    logic                 ent_present;
    logic [PN_BITS-1:0]   ent_page;
    logic [PA_BITS-1:0]   dir_addr;
    logic [PA_BITS-1:0]   pte_addr;
    logic [PA_BITS-1:0]   tbl_base;

    logic                 res_load;
    walk_fault_e          res_fault;
    logic [PA_BITS-1:0]   res_paddr;

    assign accept   = (state_q == WALK_IDLE) && req_valid;
    assign tbl_base = {ent_page, {OFF_BITS{1'b0}}};

    ptw_entry_decode #(
        .ENTRY_W (ENTRY_W),
        .PA_BITS (PA_BITS),
        .OFF_BITS(OFF_BITS)
    ) u_decode (
        .entry   (mem_rdata),
        .present (ent_present),
        .page_num(ent_page)
    );

    ptw_entry_addr #(
        .PA_BITS    (PA_BITS),
        .IDX_W      (DIR_BITS),
        .ENTRY_BYTES(ENTRY_BYTES)
    ) u_dir_addr (
        .base (root_base),
        .index(req_vaddr[OFF_BITS+IDX_BITS +: DIR_BITS]),
        .addr (dir_addr)
    );

    ptw_entry_addr #(
        .PA_BITS    (PA_BITS),
        .IDX_W      (IDX_BITS),
        .ENTRY_BYTES(ENTRY_BYTES)
    ) u_pte_addr (
        .base (tbl_base),
        .index(va_q[OFF_BITS +: IDX_BITS]),
        .addr (pte_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captured virtual address, loaded only on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q <= '0;
        end else if (accept) begin
            va_q <= req_vaddr;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WALK_IDLE:     if (req_valid) state_d = WALK_READ_DIR;
            WALK_READ_DIR: state_d = ent_present ? WALK_READ_PTE : WALK_FAULT;
            WALK_READ_PTE: state_d = ent_present ? WALK_DONE : WALK_FAULT;
            WALK_DONE:     state_d = WALK_IDLE;
            WALK_FAULT:    state_d = WALK_IDLE;
            default:       state_d = WALK_IDLE;
        endcase
    end

    // Outputs and result capture
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = pte_addr;
        rsp_valid = 1'b0;
        res_load  = 1'b0;
        res_fault = FLT_NONE;
        res_paddr = '0;
        unique case (state_q)
            WALK_IDLE: begin
                req_ready = 1'b1;
                mem_req   = req_valid;
                mem_addr  = dir_addr;
            end
            WALK_READ_DIR: begin
                mem_req = ent_present;
                if (!ent_present) begin
                    res_load  = 1'b1;
                    res_fault = FLT_DIR;
                end
            end
            WALK_READ_PTE: begin
                res_load = 1'b1;
                if (ent_present) begin
                    res_paddr = {ent_page, va_q[OFF_BITS-1:0]};
                end else begin
                    res_fault = FLT_PAGE;
                end
            end
            WALK_DONE, WALK_FAULT: begin
                rsp_valid = 1'b1;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    ptw_resp_reg #(
        .PA_BITS(PA_BITS)
    ) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (res_load),
        .fault_in(res_fault),
        .paddr_in(res_paddr),
        .fault_q (rsp_fault),
        .paddr_q (rsp_paddr)
    );

    assign rsp_vaddr = va_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VA_BITS = 13,
    parameter int PA_BITS = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [VA_BITS-1:0] req_vaddr,
    input logic               req_ready,
    input logic               mem_req,
    input logic               rsp_valid,
    input logic [1:0]         rsp_fault,
    input logic [PA_BITS-1:0] rsp_paddr,
    input logic [VA_BITS-1:0] rsp_vaddr
);
    logic [VA_BITS-1:0] va_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_seen <= '0;
        end else if (req_valid && req_ready) begin
            va_seen <= req_vaddr;
        end
    end

    // R2
    dir_read_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> mem_req);

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    not_ready_while_responding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!req_ready && !mem_req));

    // R11
    single_cycle_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R6
    fault_clears_paddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

    // R7
    legal_fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'b11));

    // R8
    response_vaddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_vaddr == va_seen));

endmodule

bind ptw_walker ptw_walker_chk #(
    .VA_BITS(VA_BITS),
    .PA_BITS(PA_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_vaddr(req_vaddr),
    .req_ready(req_ready),
    .mem_req  (mem_req),
    .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr),
    .rsp_vaddr(rsp_vaddr)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    localparam int VA_W = 13;
    localparam int PA_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PA_W-1:0] root_base = 16'h0100;
    logic            req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic            req_ready;
    logic            mem_req;
    logic [PA_W-1:0] mem_addr;
    logic [31:0]     mem_rdata = '0;
    logic            rsp_valid;
    logic [1:0]      rsp_fault;
    logic [PA_W-1:0] rsp_paddr;
    logic [VA_W-1:0] rsp_vaddr;

    int checks = 0;
    int errors = 0;
    int mode = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr)
    );

    function automatic bit dir_present(int p);
        if (mode == 1) return (p % 2) == 0;
        if (mode == 3) return p != 3;
        return 1'b1;
    endfunction

    function automatic bit pte_present(int p, int q);
        if (mode == 2) return q != ((2 * p) % 16);
        if (mode == 3) return q != 15;
        return 1'b1;
    endfunction

    function automatic logic [15:0] tbl_base(int p);
        return 16'(16'h0200 + p * 64);
    endfunction

    function automatic logic [9:0] frame_of(int p, int q);
        return 10'((p * 37 + q * 11 + 5) & 10'h3FF);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model (R3): junk in ignored bits of every entry
    always @(posedge clk) begin
        if (mem_req) begin
            int a;
            a = int'(mem_addr);
            if (a >= int'(root_base) && a < int'(root_base) + 32 && (a % 4) == 0) begin
                int p;
                p = (a - int'(root_base)) / 4;
                mem_rdata <= {16'hA5C3, tbl_base(p)[15:6], 5'b10110, dir_present(p)};
            end else if (a >= 16'h0200 && a < 16'h0400 && (a % 4) == 0) begin
                int p, q;
                p = (a - 16'h0200) / 64;
                q = (a / 4) % 16;
                mem_rdata <= {16'h5A3C, frame_of(p, q), 5'b01011, pte_present(p, q)};
            end else begin
                mem_rdata <= 32'hFFFF_FFFF;
                chk(1'b0, "R2/R4 read outside tables", {16'h0, mem_addr}, 32'h0);
            end
        end
    end

    task automatic walk(input int p, input int q, input int o);
        logic [VA_W-1:0] va;
        logic [PA_W-1:0] exp_pa;
        bit dp, pp;
        va = {3'(p), 4'(q), 6'(o)};   // R1 field layout
        dp = dir_present(p);
        pp = pte_present(p, q);
        exp_pa = {frame_of(p, q), 6'(o)};

        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        #1;
        chk(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 1);
        chk(mem_req == 1'b1, "R2 dir read strobe", 32'(mem_req), 1);
        chk(mem_addr == 16'(root_base + p * 4), "R2 dir address", 32'(mem_addr), 32'(root_base + p * 4));

        @(posedge clk);
        @(negedge clk);
        req_vaddr = ~va;               // held request must be ignored (R9)
        #1;
        chk(req_ready == 1'b0, "R9 busy in dir read", 32'(req_ready), 0);
        chk(rsp_valid == 1'b0, "R5 no early response", 32'(rsp_valid), 0);
        if (dp) begin
            chk(mem_req == 1'b1, "R4 table read strobe", 32'(mem_req), 1);
            chk(mem_addr == 16'(tbl_base(p) + q * 4), "R4 table address", 32'(mem_addr), 32'(tbl_base(p) + q * 4));
        end else begin
            chk(mem_req == 1'b0, "R6 no second read", 32'(mem_req), 0);
        end

        @(posedge clk);
        @(negedge clk);
        #1;
        if (!dp) begin
            req_valid = 1'b0;
            chk(rsp_valid == 1'b1, "R6 dir fault response", 32'(rsp_valid), 1);
            chk(rsp_fault == 2'b01, "R6 dir fault code", 32'(rsp_fault), 1);
            chk(rsp_paddr == '0, "R6 paddr zero", 32'(rsp_paddr), 0);
            chk(rsp_vaddr == va, "R8 vaddr on dir fault", 32'(rsp_vaddr), 32'(va));
        end else begin
            chk(rsp_valid == 1'b0 && req_ready == 1'b0 && mem_req == 1'b0,
                "R9 busy in table read", {29'h0, rsp_valid, req_ready, mem_req}, 0);
            @(posedge clk);
            @(negedge clk);
            #1;
            req_valid = 1'b0;
            chk(rsp_valid == 1'b1, "R5 response strobe", 32'(rsp_valid), 1);
            chk(rsp_vaddr == va, "R8 vaddr", 32'(rsp_vaddr), 32'(va));
            if (pp) begin
                chk(rsp_fault == 2'b00, "R5 ok code", 32'(rsp_fault), 0);
                chk(rsp_paddr == exp_pa, "R5 physical address", 32'(rsp_paddr), 32'(exp_pa));
            end else begin
                chk(rsp_fault == 2'b10, "R7 page fault code", 32'(rsp_fault), 2);
                chk(rsp_paddr == '0, "R7 paddr zero", 32'(rsp_paddr), 0);
            end
        end

        @(posedge clk);
        @(negedge clk);
        #1;
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R11 one-cycle response",
            {30'h0, rsp_valid, req_ready}, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R10 ready in reset", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R10 no response in reset", 32'(rsp_valid), 0);
        chk(mem_req == 1'b0, "R10 no read in reset", 32'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R10 idle after reset",
            {29'h0, req_ready, rsp_valid, mem_req}, 32'h4);

        for (int m = 0; m < 4; m++) begin
            mode = m;
            root_base = (m % 2 == 1) ? 16'h0140 : 16'h0100;
            for (int p = 0; p < 8; p++) begin
                for (int q = 0; q < 16; q++) begin
                    walk(p, q, 0);
                    walk(p, q, 63);
                    walk(p, q, (p * 5 + q * 3 + 17) % 64);
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule